// File: doc/BRIEF.md
# Stepper Axis Controller with Switch-Seeking Homing

This block runs a single motion axis through an external step/direction motor driver. It issues a square wave on a step pin and holds a direction pin alongside it. It keeps a signed position count, which advances from 4x quadrature encoder feedback and not from the pulses it sends out. A target move names an absolute position. The controller derives the direction itself, by comparing that target with the current count. It then steps until the encoder count equals the target.

Two switch inputs bound the axis. One sits at the home (negative) end and one at the far (positive) end. Each switch passes through a synchronizer and a debounce filter. A pressed switch blocks only the pulses that would drive the axis further into it; motion away from it stays allowed. A homing request drives the axis negative until the home switch closes, then clears the count to zero. The home input may be wired to a mechanical or an optical switch. Target moves are refused until homing has succeeded.

Top module: `stepper_axis_ctrl`

## Requirements
- R1: Each step pulse on `step_out` stays high for at least two clock cycles. While a move runs, rising edges repeat every P cycles, where P = `rate_div`, raised to MIN_PERIOD (default 8) when smaller.
- R2: Switch inputs are active high. While the filtered far switch is pressed, no step rising edge is issued with `dir_out`=1. While the filtered home switch is pressed, none is issued with `dir_out`=0. A move halted this way ends with `busy` low, and a move away from the pressed switch runs normally.
- R3: The first step rising edge of any motion comes at least P cycles after `dir_out` last changed.
- R4: A pulse on `home_req` while idle clears `homed`, sets `dir_out`=0 and steps until the filtered home switch is pressed. At that point `position` becomes 0, `homed` becomes 1 and `busy` falls.
- R5: `position` counts in 4x quadrature. The sequence {enc_a,enc_b} = 00→10→11→01→00 adds 1 per transition, and the reverse order subtracts 1.
- R6: A transition in which both encoder bits change at once sets `enc_err`. That flag stays set until reset, and the transition leaves `position` unchanged.
- R7: A `cmd_valid` pulse is ignored while `homed` is 0 or while `busy` is 1: no steps follow and `busy` stays low.
- R8: An accepted move raises `busy` the cycle after `cmd_valid`. It sets `dir_out`=1 when the target exceeds `position` and 0 otherwise, and keeps `busy` high until `position` equals the target. A target equal to `position` is not accepted.
- R9: If the filtered far switch is pressed during homing, the sequence aborts. `home_err` sets and stays set until reset, `busy` falls and `homed` stays 0.
- R10: A switch input reaches the control logic only after two synchronizer flops and DEB_CYCLES consecutive cycles of agreement. A shorter pulse has no effect.
- R11: After reset, `step_out`, `busy`, `homed`, `drv_en`, `enc_err`, `home_err` and `position` are all 0. `drv_en` is high whenever `busy` or `homed` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a target move |
| cmd_target | input | POS_W | Signed absolute target position |
| rate_div | input | DIV_W | Step period in clock cycles |
| home_req | input | 1 | One-cycle strobe that starts homing |
| lim_home | input | 1 | Home-end switch, active high, asynchronous |
| lim_far | input | 1 | Far-end switch, active high, asynchronous |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| step_out | output | 1 | Step square wave to the driver |
| dir_out | output | 1 | Direction to the driver, 1 = positive |
| drv_en | output | 1 | Driver enable |
| busy | output | 1 | Motion or homing in progress |
| homed | output | 1 | Position reference established |
| position | output | POS_W | Signed encoder position |
| enc_err | output | 1 | Sticky illegal-encoder-transition flag |
| home_err | output | 1 | Sticky homing-abort flag |

## Verification
The bench stops a move by pressing the far switch right after a step. A controller that ignored the filtered switch would keep pulsing into the stop, and one that blocked both directions would refuse the return move that follows. It injects a two-cycle glitch on the home switch during a negative move; a missing debounce would cut that move short. It forces a double-bit encoder jump, which a naive decoder would count as two steps. It requests homing with the far switch closed, and a controller that did not abort would then step toward a wiring fault. Timing monitors record every step edge, so a shortened high phase, a period below the floor, or a rising edge that arrives before direction has had a full period to settle each shows up as a failed check.

// File: rtl/stepper_axis_pkg.sv
// Shared types for the stepper axis controller.
package stepper_axis_pkg;

    typedef enum logic [1:0] {
        AX_IDLE  = 2'd0,
        AX_SETUP = 2'd1,
        AX_MOVE  = 2'd2,
        AX_HOME  = 2'd3
    } axis_state_t;

    localparam int SW_HOME  = 0;
    localparam int SW_FAR   = 1;
    localparam int SW_COUNT = 2;

endpackage

// File: rtl/stepper_switch_filter.sv
// Two-flop synchronizer plus debounce for one switch input.
// Assumes: raw_i is asynchronous; DEB_CYCLES >= 1. The output takes the
// synchronized value only after it has differed for DEB_CYCLES edges in a row.
module stepper_switch_filter #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CNT_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_CYCLES - 1);

    logic             sync1_q, sync2_q;
    logic [CNT_W-1:0] cnt_q;

    // Bring the raw level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
        end
    end

    // Accept a new level only after it has held for the whole window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_o <= 1'b0;
        end else if (sync2_q == filt_o) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            filt_o <= sync2_q;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/stepper_quad_decoder.sv
// 4x quadrature decoder. Emits one-cycle inc/dec/bad pulses.
// Assumes: A/B are asynchronous. Positive order of {a,b}: 00,10,11,01.
// Decoding starts only once the synchronizer holds real samples.
module stepper_quad_decoder (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    output logic inc_o,
    output logic dec_o,
    output logic bad_o
);
    logic       a1_q, a2_q, b1_q, b2_q;
    logic [1:0] prev_idx_q;
    logic [1:0] prime_q;
    logic [1:0] cur_idx, delta;
    logic       live;

    assign cur_idx = {b2_q, a2_q ^ b2_q};
    assign delta   = cur_idx - prev_idx_q;
    assign live    = (prime_q == 2'd3);
    assign inc_o   = live && (delta == 2'd1);
    assign dec_o   = live && (delta == 2'd3);
    assign bad_o   = live && (delta == 2'd2);

    // Synchronize both channels and remember the last phase index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a1_q       <= 1'b0;
            a2_q       <= 1'b0;
            b1_q       <= 1'b0;
            b2_q       <= 1'b0;
            prev_idx_q <= 2'd0;
        end else begin
            a1_q       <= enc_a;
            a2_q       <= a1_q;
            b1_q       <= enc_b;
            b2_q       <= b1_q;
            prev_idx_q <= cur_idx;
        end
    end

    // Count out the synchronizer fill before trusting the comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)              prime_q <= 2'd0;
        else if (prime_q != 2'd3) prime_q <= prime_q + 1'b1;
    end
endmodule

// File: rtl/stepper_pulse_gen.sv
// Step square-wave generator. The period is rate_div clamped to MIN_PERIOD
// and is latched at each rising edge; the high phase is half the period.
// Assumes: MIN_PERIOD >= 4, so the high phase lasts at least two cycles.
// Dropping en lets the current period finish without a new rising edge.
module stepper_pulse_gen #(
    parameter int DIV_W      = 16,
    parameter int MIN_PERIOD = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] rate_div,
    output logic             step_o,
    output logic             active_o,
    output logic [DIV_W-1:0] period_o
);
    localparam logic [DIV_W-1:0] MIN_P = DIV_W'(MIN_PERIOD);

    logic [DIV_W-1:0] per_q, cnt_q, cnt_nxt, half;

    assign period_o = (rate_div < MIN_P) ? MIN_P : rate_div;
    assign half     = per_q >> 1;
    assign cnt_nxt  = cnt_q + 1'b1;

    // Run the period counter and shape the high and low phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q    <= MIN_P;
            cnt_q    <= '0;
            active_o <= 1'b0;
            step_o   <= 1'b0;
        end else if (!active_o) begin
            if (en) begin
                active_o <= 1'b1;
                per_q    <= period_o;
                cnt_q    <= '0;
                step_o   <= 1'b1;
            end
        end else if (cnt_q == per_q - 1'b1) begin
            cnt_q <= '0;
            if (en) begin
                per_q  <= period_o;
                step_o <= 1'b1;
            end else begin
                active_o <= 1'b0;
                step_o   <= 1'b0;
            end
        end else begin
            cnt_q  <= cnt_nxt;
            step_o <= (cnt_nxt < half);
        end
    end
endmodule

// File: rtl/stepper_axis_ctrl.sv
// One stepper axis: switch filtering, interlocked stepping, homing and an
// encoder-tracked signed position.
// Assumes: home switch at the negative end, far switch at the positive end,
// switches active high, encoder steady at reset. A home hit that coincides
// with an encoder count gives priority to the zeroing.
module stepper_axis_ctrl
    import stepper_axis_pkg::*;
#(
    parameter int POS_W      = 32,
    parameter int DIV_W      = 16,
    parameter int MIN_PERIOD = 8,
    parameter int DEB_CYCLES = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [POS_W-1:0] cmd_target,
    input  logic [DIV_W-1:0] rate_div,
    input  logic             home_req,
    input  logic             lim_home,
    input  logic             lim_far,
    input  logic             enc_a,
    input  logic             enc_b,
    output logic             step_out,
    output logic             dir_out,
    output logic             drv_en,
    output logic             busy,
    output logic             homed,
    output logic [POS_W-1:0] position,
    output logic             enc_err,
    output logic             home_err
);
    axis_state_t      st_q;
    logic             dir_q, seek_home_q, homed_q, home_err_q, enc_err_q;
    logic [POS_W-1:0] pos_q, tgt_q;
    logic [DIV_W-1:0] set_cnt_q, period_now, set_last;
    logic [SW_COUNT-1:0] sw_raw, sw_filt;
    logic             home_f, far_f, blk, at_tgt, home_hit, gen_en, gen_active;
    logic             enc_inc, enc_dec, enc_bad;

    assign sw_raw = {lim_far, lim_home};

    for (genvar g = 0; g < SW_COUNT; g++) begin : g_sw
        stepper_switch_filter #(.DEB_CYCLES(DEB_CYCLES)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (sw_raw[g]),
            .filt_o (sw_filt[g])
        );
    end

    assign home_f   = sw_filt[SW_HOME];
    assign far_f    = sw_filt[SW_FAR];
    assign blk      = dir_q ? far_f : home_f;
    assign at_tgt   = (pos_q == tgt_q);
    assign home_hit = (st_q == AX_HOME) && home_f && !far_f;
    assign gen_en   = !blk && (((st_q == AX_MOVE) && !at_tgt) ||
                               ((st_q == AX_HOME) && !far_f));
    assign set_last = period_now - 1'b1;

    stepper_quad_decoder u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .enc_a (enc_a),
        .enc_b (enc_b),
        .inc_o (enc_inc),
        .dec_o (enc_dec),
        .bad_o (enc_bad)
    );

    stepper_pulse_gen #(.DIV_W(DIV_W), .MIN_PERIOD(MIN_PERIOD)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (gen_en),
        .rate_div (rate_div),
        .step_o   (step_out),
        .active_o (gen_active),
        .period_o (period_now)
    );

    // Sequence commands: accept, hold direction for a period, step, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= AX_IDLE;
            dir_q       <= 1'b0;
            seek_home_q <= 1'b0;
            homed_q     <= 1'b0;
            home_err_q  <= 1'b0;
            tgt_q       <= '0;
            set_cnt_q   <= '0;
        end else begin
            case (st_q)
                AX_IDLE: begin
                    if (home_req) begin
                        homed_q     <= 1'b0;
                        dir_q       <= 1'b0;
                        seek_home_q <= 1'b1;
                        set_cnt_q   <= '0;
                        st_q        <= AX_SETUP;
                    end else if (cmd_valid && homed_q && (cmd_target != pos_q)) begin
                        tgt_q       <= cmd_target;
                        dir_q       <= ($signed(cmd_target) > $signed(pos_q));
                        seek_home_q <= 1'b0;
                        set_cnt_q   <= '0;
                        st_q        <= AX_SETUP;
                    end
                end
                AX_SETUP: begin
                    if (set_cnt_q >= set_last) begin
                        if (!gen_active) st_q <= seek_home_q ? AX_HOME : AX_MOVE;
                    end else begin
                        set_cnt_q <= set_cnt_q + 1'b1;
                    end
                end
                AX_HOME: begin
                    if (far_f) begin
                        home_err_q <= 1'b1;
                        st_q       <= AX_IDLE;
                    end else if (home_f) begin
                        homed_q <= 1'b1;
                        st_q    <= AX_IDLE;
                    end
                end
                AX_MOVE: begin
                    if (at_tgt || blk) st_q <= AX_IDLE;
                end
                default: st_q <= AX_IDLE;
            endcase
        end
    end

    // Track position from the encoder; zero it on the homing hit.
    always_ff @(posedge clk) begin
        if (!rst_n)        pos_q <= '0;
        else if (home_hit) pos_q <= '0;
        else if (enc_inc)  pos_q <= pos_q + 1'b1;
        else if (enc_dec)  pos_q <= pos_q - 1'b1;
    end

    // Latch any illegal encoder transition until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       enc_err_q <= 1'b0;
        else if (enc_bad) enc_err_q <= 1'b1;
    end

    assign dir_out  = dir_q;
    assign busy     = (st_q != AX_IDLE);
    assign homed    = homed_q;
    assign drv_en   = busy || homed_q;
    assign position = pos_q;
    assign enc_err  = enc_err_q;
    assign home_err = home_err_q;
endmodule

// File: rtl/stepper_axis_chk.sv
// Property checker for stepper_axis_ctrl, attached by bind below.
// Assumes: the filtered switch levels and decoder pulses are visible by name.
module stepper_axis_chk #(
    parameter int POS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_out,
    input logic             dir_out,
    input logic             home_f,
    input logic             far_f,
    input logic             homed,
    input logic             busy,
    input logic [POS_W-1:0] position,
    input logic             cmd_valid,
    input logic             home_req,
    input logic             enc_err,
    input logic             home_err,
    input logic             enc_bad,
    input logic             home_hit
);
    p_step_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_out) |-> $past(step_out, 2));

    p_interlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_out) |-> !(($past(dir_out) && $past(far_f)) ||
                              (!$past(dir_out) && $past(home_f))));

    p_dir_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_out) |-> $stable(dir_out));

    p_home_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(homed) |-> (position == '0));

    p_enc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_bad && !home_hit) |=> $stable(position));

    p_enc_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enc_err |=> enc_err);

    p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!homed && !busy && cmd_valid && !home_req) |=> !busy);

    p_home_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(home_err) |-> (!busy && !homed));
endmodule

bind stepper_axis_ctrl stepper_axis_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_out  (step_out),
    .dir_out   (dir_out),
    .home_f    (home_f),
    .far_f     (far_f),
    .homed     (homed),
    .busy      (busy),
    .position  (position),
    .cmd_valid (cmd_valid),
    .home_req  (home_req),
    .enc_err   (enc_err),
    .home_err  (home_err),
    .enc_bad   (enc_bad),
    .home_hit  (home_hit)
);

// File: tb/stepper_axis_ctrl_tb_top.sv
// Bench: a mechanical encoder model turns every step edge into one
// quadrature count; a vector table of moves runs first, then directed tests.
module stepper_axis_ctrl_tb_top;
    localparam int POS_W = 32;
    localparam int DIV_W = 16;
    localparam int MINP  = 8;
    localparam int DEB   = 4;
    localparam int NV    = 4;
    localparam int V_TGT [NV] = '{25, 10, -3, 40};
    localparam int V_DIV [NV] = '{8, 12, 3, 20};
    localparam bit V_GLT [NV] = '{1'b0, 1'b1, 1'b0, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [POS_W-1:0] cmd_target = '0;
    logic [DIV_W-1:0] rate_div = 16'd8;
    logic home_req = 1'b0, lim_home = 1'b0, lim_far = 1'b0;
    logic enc_a, enc_b;
    logic step_out, dir_out, drv_en, busy, homed, enc_err, home_err;
    logic [POS_W-1:0] position;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    int net = 0;
    logic [1:0] idx = 2'd0, skew = 2'd0, idx_eff;
    int cyc = 0, last_rise = -1, dir_chg = 0, hi_len = 0, last_int = 0;
    int cur_per = 40, width_viol = 0, per_viol = 0, setup_viol = 0;
    logic step_prev = 1'b0, dir_prev = 1'b0;

    always #5 clk = ~clk;

    stepper_axis_ctrl #(.POS_W(POS_W), .DIV_W(DIV_W), .MIN_PERIOD(MINP),
                        .DEB_CYCLES(DEB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_target(cmd_target),
        .rate_div(rate_div), .home_req(home_req), .lim_home(lim_home),
        .lim_far(lim_far), .enc_a(enc_a), .enc_b(enc_b), .step_out(step_out),
        .dir_out(dir_out), .drv_en(drv_en), .busy(busy), .homed(homed),
        .position(position), .enc_err(enc_err), .home_err(home_err));

    // Encoder model: one quadrature count per step, in the driven direction.
    always @(posedge step_out) begin
        if (dir_out) begin net++; idx <= idx + 2'd1; end
        else begin net--; idx <= idx - 2'd1; end
    end
    assign idx_eff = idx + skew;
    assign enc_a   = (idx_eff == 2'd1) || (idx_eff == 2'd2);
    assign enc_b   = idx_eff[1];

    // Step timing monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (dir_out !== dir_prev) dir_chg = cyc;
        if (step_out && !step_prev) begin
            if (last_rise >= 0) begin
                last_int = cyc - last_rise;
                if (last_int < cur_per) per_viol++;
            end
            if (cyc - dir_chg < cur_per) setup_viol++;
            last_rise = cyc;
            hi_len = 1;
        end else if (step_out) begin
            hi_len++;
        end else if (step_prev && hi_len < 2) begin
            width_viol++;
        end
        step_prev = step_out;
        dir_prev  = dir_out;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue_move(input int tgt, input int div);
        @(negedge clk);
        cur_per    = (div < MINP) ? MINP : div;
        rate_div   = DIV_W'(div);
        cmd_target = POS_W'(tgt);
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic wait_idle();
        for (int w = 0; w < 20000 && busy; w++) @(negedge clk);
        tick(12);
    endtask

    task automatic wait_net(input int val);
        for (int w = 0; w < 5000 && net != val; w++) @(negedge clk);
    endtask

    function automatic longint spos();
        return longint'($signed(position));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int prev;
        int base;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R11: reset state
        chk("R11 step", step_out, 0);
        chk("R11 busy", busy, 0);
        chk("R11 homed", homed, 0);
        chk("R11 drv_en", drv_en, 0);
        chk("R11 errors", {enc_err, home_err}, 0);
        chk("R11 position", spos(), 0);

        // R7: move refused before homing
        issue_move(50, 8);
        tick(40);
        chk("R7 busy unhomed", busy, 0);
        chk("R7 no steps unhomed", net, 0);

        // R4: homing toward the home switch
        @(negedge clk); cur_per = 40; rate_div = 16'd40; home_req = 1'b1;
        @(negedge clk); home_req = 1'b0;
        chk("R4 busy homing", busy, 1);
        chk("R4 drv_en busy", drv_en, 1);
        wait_net(-5);
        lim_home = 1'b1;
        chk("R4 dir negative", dir_out, 0);
        wait_idle();
        chk("R4 homed", homed, 1);
        chk("R4 position zero", spos(), 0);
        chk("R4 busy done", busy, 0);
        chk("R2 no step into home", net, -5);
        lim_home = 1'b0;
        tick(12);
        chk("R11 drv_en homed", drv_en, 1);

        // R8: target equal to position is not accepted
        issue_move(0, 8);
        chk("R8 equal target busy", busy, 0);

        // R1 R3 R5 R8 R10: vector table of moves
        prev = 0;
        for (int i = 0; i < NV; i++) begin
            base = net;
            issue_move(V_TGT[i], V_DIV[i]);
            chk("R8 busy after accept", busy, 1);
            if (V_GLT[i]) begin
                tick(30);
                lim_home = 1'b1; tick(2); lim_home = 1'b0;
            end
            wait_idle();
            chk("R8 dir polarity", dir_out, (V_TGT[i] > prev) ? 1 : 0);
            chk("R5 position tracks", spos(), V_TGT[i]);
            chk("R10 R8 step count", net - base, V_TGT[i] - prev);
            chk("R1 period", last_int, (V_DIV[i] < MINP) ? MINP : V_DIV[i]);
            chk("R8 busy released", busy, 0);
            prev = V_TGT[i];
        end

        // R2: far switch halts a positive move and allows the way back
        base = net;
        issue_move(100, 8);
        wait_net(base + 5);
        lim_far = 1'b1;
        tick(60);
        chk("R2 halted busy", busy, 0);
        chk("R2 halted steps", net - base, 5);
        chk("R2 halted position", spos(), 45);
        issue_move(30, 8);
        wait_idle();
        chk("R2 away from far", spos(), 30);
        base = net;
        issue_move(60, 8);
        wait_idle();
        chk("R2 toward far blocked", net - base, 0);
        chk("R2 toward far busy", busy, 0);
        chk("R2 toward far position", spos(), 30);
        lim_far = 1'b0;
        tick(12);

        // R6: illegal double-bit encoder jump
        skew = 2'd2;
        tick(10);
        chk("R6 enc_err set", enc_err, 1);
        chk("R6 position held", spos(), 30);
        skew = 2'd0;
        tick(10);
        chk("R6 enc_err sticky", enc_err, 1);
        chk("R6 position held again", spos(), 30);

        // R9: far switch during homing aborts the sequence
        lim_far = 1'b1;
        tick(12);
        base = net;
        @(negedge clk); cur_per = 8; rate_div = 16'd8; home_req = 1'b1;
        @(negedge clk); home_req = 1'b0;
        wait_idle();
        chk("R9 home_err", home_err, 1);
        chk("R9 homed clear", homed, 0);
        chk("R9 busy", busy, 0);
        chk("R9 no steps", net - base, 0);
        lim_far = 1'b0;
        tick(12);
        issue_move(10, 8);
        tick(20);
        chk("R7 refused after abort", busy, 0);

        // R1 R3: accumulated timing monitor results
        chk("R1 high width", width_viol, 0);
        chk("R1 period floor", per_viol, 0);
        chk("R3 direction setup", setup_viol, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule